// File: doc/BRIEF.md
# Peripheral Interrupt Status Controller

This block keeps the pending-interrupt bookkeeping for a serial peripheral that raises four kinds of event: transmit watermark reached, receive watermark reached, transmitter drained and receive overflow. Single-cycle event pulses from the datapath mark a source as pending. Software clears pending sources by writing ones to the status word. It can also raise them on purpose through a test word that is written only.

A one-bit enable mask gates each pending source onto its own level interrupt line. The lines are registered, so they follow the status and mask one clock later. Everything is reached over a simple 32-bit register bus with byte addresses. Status is at 0x00, the mask at 0x04 and the test word at 0x08. Reads take no cycle: the read data is a pure function of the address and the current state.

Top module: `isc_top`

## Requirements
- R1: After reset the status word and the enable mask both read as zero, and all four interrupt lines are low.
- R2: A one-cycle pulse on an event input sets its status bit at the next clock edge. The bit positions are: transmit watermark bit 0, receive watermark bit 1, transmit drained bit 2, receive overflow bit 3.
- R3: A write to the status word (address 0x00) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: A write to the test word (address 0x08) ORs the written low four bits into the status word.
- R5: Each interrupt line equals the AND of its status bit and its enable bit, as those held one clock earlier.
- R6: The enable mask (address 0x04) is plain read/write storage, and writing it never changes the status word.
- R7: A read of the test word returns zero.
- R8: Bits 31:4 of the status, enable and test words read as zero, and written ones in those bits have no effect.
- R9: When an event pulse and a software clear reach the same status bit in the same cycle, the bit ends up set.
- R10: A write to any other address, including a misaligned one, changes neither the status nor the mask, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| evt_tx_wmark | input | 1 | Event pulse: transmit watermark |
| evt_rx_wmark | input | 1 | Event pulse: receive watermark |
| evt_tx_empty | input | 1 | Event pulse: transmitter drained |
| evt_rx_ovf | input | 1 | Event pulse: receive overflow |
| irq_tx_wmark | output | 1 | Level interrupt: transmit watermark |
| irq_rx_wmark | output | 1 | Level interrupt: receive watermark |
| irq_tx_empty | output | 1 | Level interrupt: transmitter drained |
| irq_rx_ovf | output | 1 | Level interrupt: receive overflow |

## Verification
The status word is driven by three kinds of stimulus: single event pulses, two event pulses in the same cycle, and event pulses that coincide with a write-one clear. These separate a correct per-bit update from one that mixes up bit positions or lets the clear win. Clear masks of all zeros, of mixed bits and of all ones show that a write to status touches only the bits written as one. Writes to the test word, to the upper bits and to unmapped or misaligned addresses separate real storage from decode leaks. Changing the enable mask while sources are pending, and sampling the lines in the cycle right after, shows the one-clock delay and shows that the mask never disturbs the status.

// File: rtl/isc_pkg.sv
package isc_pkg;

  localparam int SRC_COUNT = 4;

  // source index inside the status, enable and test words
  typedef enum int {
    SRC_TX_WMARK = 0,
    SRC_RX_WMARK = 1,
    SRC_TX_EMPTY = 2,
    SRC_RX_OVF   = 3
  } src_idx_e;

  // byte offsets of the three words
  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_ENABLE = 8'h04;
  localparam logic [7:0] OFS_TEST   = 8'h08;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_TEST   = 2'd3
  } rd_sel_e;

  // next value of one status bit: set beats clear
  function automatic logic status_next(input logic cur, input logic set,
                                       input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  // zero-extend a source field to a bus word
  function automatic logic [31:0] widen(input logic [SRC_COUNT-1:0] f);
    logic [31:0] w;
    w = '0;
    w[SRC_COUNT-1:0] = f;
    return w;
  endfunction

endpackage

// File: rtl/isc_decode.sv
module isc_decode
  import isc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_status_o,
  output logic              wr_enable_o,
  output logic              wr_test_o,
  output rd_sel_e           rd_sel_o
);

  logic hit_status, hit_enable, hit_test;

  assign hit_status = (addr_i == ADDR_W'(OFS_STATUS));
  assign hit_enable = (addr_i == ADDR_W'(OFS_ENABLE));
  assign hit_test   = (addr_i == ADDR_W'(OFS_TEST));

  assign wr_status_o = req_i && we_i && hit_status;
  assign wr_enable_o = req_i && we_i && hit_enable;
  assign wr_test_o   = req_i && we_i && hit_test;

  always_comb begin
    if (hit_status)      rd_sel_o = SEL_STATUS;
    else if (hit_enable) rd_sel_o = SEL_ENABLE;
    else if (hit_test)   rd_sel_o = SEL_TEST;
    else                 rd_sel_o = SEL_NONE;
  end

endmodule

// File: rtl/isc_state_bank.sv
module isc_state_bank
  import isc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] state_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o[i] <= 1'b0;
      else        state_o[i] <= status_next(state_o[i], set_i[i], clr_i[i]);
    end
  end

endmodule

// File: rtl/isc_enable_reg.sv
module isc_enable_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] value_i,
  output logic [N-1:0] mask_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_o <= '0;
    else if (load_i) mask_o <= value_i;
  end

endmodule

// File: rtl/isc_irq_drive.sv
module isc_irq_drive #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] state_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] line_o
);

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_o[i] <= 1'b0;
      else        line_o[i] <= state_i[i] & mask_i[i];
    end
  end

endmodule

// File: rtl/isc_top.sv
module isc_top
  import isc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_tx_wmark,
  input  logic              evt_rx_wmark,
  input  logic              evt_tx_empty,
  input  logic              evt_rx_ovf,
  output logic              irq_tx_wmark,
  output logic              irq_rx_wmark,
  output logic              irq_tx_empty,
  output logic              irq_rx_ovf
);

  localparam int N = SRC_COUNT;

  // named internal events, also watched by the checker
  logic          wr_status, wr_enable, wr_test;
  rd_sel_e       rd_sel;
  logic [N-1:0]  hw_set, sw_clr, sw_force, any_set;
  logic [N-1:0]  state_q, enable_q, irq_q;
  logic [N-1:0]  wfield;

  assign wfield = bus_wdata[N-1:0];

  assign hw_set[SRC_TX_WMARK] = evt_tx_wmark;
  assign hw_set[SRC_RX_WMARK] = evt_rx_wmark;
  assign hw_set[SRC_TX_EMPTY] = evt_tx_empty;
  assign hw_set[SRC_RX_OVF]   = evt_rx_ovf;

  assign sw_clr   = wr_status ? wfield : '0;
  assign sw_force = wr_test   ? wfield : '0;
  assign any_set  = hw_set | sw_force;

  isc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i       (bus_req),
    .we_i        (bus_we),
    .addr_i      (bus_addr),
    .wr_status_o (wr_status),
    .wr_enable_o (wr_enable),
    .wr_test_o   (wr_test),
    .rd_sel_o    (rd_sel)
  );

  isc_state_bank #(.N(N)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (any_set),
    .clr_i   (sw_clr),
    .state_o (state_q)
  );

  isc_enable_reg #(.N(N)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (wr_enable),
    .value_i (wfield),
    .mask_o  (enable_q)
  );

  isc_irq_drive #(.N(N)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (state_q),
    .mask_i  (enable_q),
    .line_o  (irq_q)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_STATUS: bus_rdata = DATA_W'(widen(state_q));
      SEL_ENABLE: bus_rdata = DATA_W'(widen(enable_q));
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_tx_wmark = irq_q[SRC_TX_WMARK];
  assign irq_rx_wmark = irq_q[SRC_RX_WMARK];
  assign irq_tx_empty = irq_q[SRC_TX_EMPTY];
  assign irq_rx_ovf   = irq_q[SRC_RX_OVF];

endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int N      = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wr_status,
  input logic              wr_enable,
  input logic              wr_test,
  input logic [N-1:0]      hw_set,
  input logic [N-1:0]      state_q,
  input logic [N-1:0]      enable_q,
  input logic [N-1:0]      irq_q
);

  logic [N-1:0] wf;
  assign wf = bus_wdata[N-1:0];

  // R1
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (state_q == '0 && enable_q == '0 && irq_q == '0));

  // R2
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((state_q & $past(hw_set)) == $past(hw_set)));

  // R3
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && hw_set == '0) |=>
      (state_q == ($past(state_q) & ~$past(wf))));

  // R4
  p_test_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_test |=> ((state_q & $past(wf)) == $past(wf)));

  // R5
  p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == ($past(state_q) & $past(enable_q))));

  // R6
  p_enable_keeps_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && hw_set == '0) |=> (state_q == $past(state_q)));

  // R7
  p_test_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == ADDR_W'(8'h08)) |-> (bus_rdata == '0));

  // R8
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:N] == '0);

  // R9
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && (|(hw_set & wf))) |=>
      ((state_q & $past(hw_set)) == $past(hw_set)));

  // R10
  p_unmapped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !wr_status && !wr_enable && !wr_test && hw_set == '0)
      |=> (state_q == $past(state_q) && enable_q == $past(enable_q)));

endmodule

bind isc_top isc_checker #(
  .N(isc_pkg::SRC_COUNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .wr_status (wr_status),
  .wr_enable (wr_enable),
  .wr_test   (wr_test),
  .hw_set    (hw_set),
  .state_q   (state_q),
  .enable_q  (enable_q),
  .irq_q     (irq_q)
);

// File: tb/sim_isc_top.sv
module sim_isc_top;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  evt = '0;
  logic        irq_tx_wmark, irq_rx_wmark, irq_tx_empty, irq_rx_ovf;
  logic [3:0]  irq_vec;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  isc_top u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_tx_wmark(evt[0]), .evt_rx_wmark(evt[1]),
    .evt_tx_empty(evt[2]), .evt_rx_ovf(evt[3]),
    .irq_tx_wmark(irq_tx_wmark), .irq_rx_wmark(irq_rx_wmark),
    .irq_tx_empty(irq_tx_empty), .irq_rx_ovf(irq_rx_ovf)
  );

  assign irq_vec = {irq_rx_ovf, irq_tx_empty, irq_rx_wmark, irq_tx_wmark};

  // behavioural reference: pending set, mask, delayed lines
  int m_pend = 0, m_mask = 0, m_lines = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 0; m_mask <= 0; m_lines <= 0;
    end else begin
      int clr, frc, nxt;
      clr = 0; frc = 0;
      if (bus_req && bus_we && bus_addr == 8'h00) clr = int'(bus_wdata) & 15;
      if (bus_req && bus_we && bus_addr == 8'h08) frc = int'(bus_wdata) & 15;
      nxt = m_pend;
      for (int b = 0; b < 4; b++) begin
        if (((clr >> b) & 1) == 1) nxt = nxt & ~(1 << b);
      end
      nxt = nxt | frc | int'(evt);
      m_lines <= m_pend & m_mask;
      m_pend  <= nxt;
      if (bus_req && bus_we && bus_addr == 8'h04) m_mask <= int'(bus_wdata) & 15;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  // every cycle: the lines must match the reference (R5)
  always @(negedge clk) begin
    if (rst_n) begin
      #1;
      chk("R5 per-cycle lines", int'(irq_vec), m_lines);
    end
  end

  task automatic cycle(input logic we, input logic [7:0] a,
                       input logic [31:0] d, input logic [3:0] e);
    @(negedge clk);
    bus_req = we; bus_we = we; bus_addr = a; bus_wdata = d; evt = e;
    @(negedge clk);
    bus_req = 0; bus_we = 0; evt = '0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #(PERIOD/4);
    v = int'(bus_rdata);
    bus_req = 0;
  endtask

  initial begin
    #(PERIOD*20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h00, v); chk("R1 status after reset", v, 0);
    rd(8'h04, v); chk("R1 enable after reset", v, 0);
    chk("R1 lines after reset", int'(irq_vec), 0);

    cycle(0, 8'h00, 0, 4'b0001);
    rd(8'h00, v); chk("R2 tx watermark bit0", v, 'h1);
    cycle(0, 8'h00, 0, 4'b1000);
    rd(8'h00, v); chk("R2 rx overflow bit3", v, 'h9);
    cycle(0, 8'h00, 0, 4'b0110);
    rd(8'h00, v); chk("R2 two events together", v, 'hF);

    cycle(1, 8'h00, 32'h5, 4'b0000);
    rd(8'h00, v); chk("R3 clear bits 0 and 2", v, 'hA);
    cycle(1, 8'h00, 32'h0, 4'b0000);
    rd(8'h00, v); chk("R3 zero write keeps", v, 'hA);

    cycle(1, 8'h04, 32'h3, 4'b0000);
    rd(8'h00, v); chk("R6 status unchanged by enable", v, 'hA);
    rd(8'h04, v); chk("R6 enable reads back", v, 'h3);
    chk("R5 line rx watermark", int'(irq_vec), 'h2);

    // one-cycle latency of the lines after a mask change
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 8'h04; bus_wdata = 32'h8;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    #1 chk("R5 lines hold one cycle", int'(irq_vec), 'h2);
    @(negedge clk);
    #1 chk("R5 lines follow mask", int'(irq_vec), 'h8);

    cycle(1, 8'h08, 32'h5, 4'b0000);
    rd(8'h00, v); chk("R4 test ORs in", v, 'hF);
    rd(8'h08, v); chk("R7 test reads zero", v, 0);

    cycle(1, 8'h00, 32'hF, 4'b0000);
    rd(8'h00, v); chk("R3 clear all", v, 0);
    cycle(1, 8'h04, 32'hFFFF_FFF0, 4'b0000);
    rd(8'h04, v); chk("R8 enable upper ignored", v, 0);
    cycle(1, 8'h08, 32'hFFFF_FFF0, 4'b0000);
    rd(8'h00, v); chk("R8 test upper ignored", v, 0);
    cycle(1, 8'h04, 32'hFFFF_FFFF, 4'b0000);
    rd(8'h04, v); chk("R8 enable reads low four", v, 'hF);

    cycle(1, 8'h08, 32'hF, 4'b0000);
    cycle(1, 8'h00, 32'hF, 4'b0100);
    rd(8'h00, v); chk("R9 set beats clear", v, 'h4);

    cycle(1, 8'h0C, 32'hF, 4'b0000);
    cycle(1, 8'h01, 32'hF, 4'b0000);
    cycle(1, 8'h05, 32'h0, 4'b0000);
    rd(8'h00, v); chk("R10 status untouched", v, 'h4);
    rd(8'h04, v); chk("R10 enable untouched", v, 'hF);
    rd(8'h0C, v); chk("R10 unmapped reads zero", v, 0);
    chk("R5 final lines", int'(irq_vec), 'h4);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule